// File: doc/BRIEF.md
# I2C Start Condition Generator with Bus Collision Detection

This block produces the Start condition of a single I2C bus master. It pulls the open-drain SDA line low and then SCL, each after a programmable delay, and it watches both lines for another master on the bus. Software or a controller sequencer fires a one-cycle start request. The block then runs two timed phases. A collision found at any point where the rules apply ends the attempt: the block returns to idle, releases both lines and raises a sticky collision flag.

The raw SDA and SCL levels pass through a two-flop synchronizer before any decision uses them. Each phase lasts `reload_i + 1` clock cycles. The two collision rules differ between the phases. In the first phase, a low SCL while SDA is still high is a collision, and a low SDA only makes the block drive SDA at once and move on. In the second phase, SCL going low is ignored. After a good Start, both lines stay held low until the synchronous soft reset `srst_i` hands the bus on.

Top module: `i2c_start_gen`

## Requirements
- R1: After the asynchronous reset, `sda_pd_o`, `scl_pd_o`, `irq_o`, `bcl_o` and `start_clr_o` are all 0.
- R2: If `start_i` arrives in idle while synchronized SDA or SCL is low, then on the next cycle `bcl_o`, `irq_o` and the one-cycle `start_clr_o` are 1, and neither line is driven.
- R3: If both lines are high when `start_i` is accepted, the first phase lasts `reload_i + 1` cycles. `sda_pd_o` rises `reload_i + 1` clock edges after the edge that accepted the start.
- R4: In the first phase, synchronized SCL low with SDA high is a collision. `bcl_o` and `irq_o` set, `start_clr_o` pulses, and the block goes idle with both lines released.
- R5: In the first phase, synchronized SDA low drives `sda_pd_o` on the next cycle with no collision. A full second phase of `reload_i + 1` cycles follows.
- R6: The second phase lasts `reload_i + 1` cycles. At its end `scl_pd_o` rises, `irq_o` sets and `start_clr_o` pulses for one cycle, while `bcl_o` stays 0.
- R7: SCL low during the second phase has no effect: the phase runs its full length and `bcl_o` stays 0.
- R8: `irq_o` and `bcl_o` hold until their own clear inputs `irq_clr_i` and `bcl_clr_i` are pulsed. Each clear leaves the other flag alone, and a setting event wins over a clear in the same cycle.
- R9: `start_i` is ignored unless the block is idle. During a phase, a second request does not change the timing. After completion, a request changes no output.
- R10: `srst_i` returns the block to idle on the next edge. It releases both lines and clears both flags.
- R11: A line change is acted on at the third rising clock edge after it appears at the pin (two synchronizer stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous soft reset; releases lines, clears flags |
| start_i | input | 1 | One-cycle Start request |
| reload_i | input | RELOAD_W | Delay reload value for each phase |
| sda_i | input | 1 | Raw SDA level at the pin |
| scl_i | input | 1 | Raw SCL level at the pin |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| bcl_clr_i | input | 1 | Clears the collision flag |
| sda_pd_o | output | 1 | Pull SDA low |
| scl_pd_o | output | 1 | Pull SCL low |
| irq_o | output | 1 | Sticky interrupt flag |
| bcl_o | output | 1 | Sticky bus collision flag |
| start_clr_o | output | 1 | One-cycle pulse that clears the start request |

## Verification
The bench measures both phase lengths edge by edge for random reload values, including zero. An off-by-one counter would move the SDA or SCL edge by one cycle. It pulls SDA low in the first phase to catch a design that treats the early drive as a collision, or that shortens the second phase. It pulls SCL low in each phase to catch a design that swaps the two rules. It also covers a line that is already low at the request, a repeated request while busy or done, and clearing one flag while the other stays set. These catch a block that restarts, fails to abort, or clears both flags together.

// File: rtl/i2c_sg_pkg.sv
package i2c_sg_pkg;
  parameter int unsigned RELOAD_W = 7;
  parameter int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SG_IDLE = 2'd0,
    SG_PH1  = 2'd1,
    SG_PH2  = 2'd2,
    SG_DONE = 2'd3
  } sg_state_e;
endpackage

// File: rtl/i2c_sg_sync.sv
module i2c_sg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      // idle bus level is high
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_sg_cnt.sv
module i2c_sg_cnt #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [WIDTH-1:0] reload_i,
  output logic             zero_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (load_i)              cnt_q <= reload_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_sg_fsm.sv
module i2c_sg_fsm
  import i2c_sg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic start_i,
  input  logic sda_s_i,
  input  logic scl_s_i,
  input  logic cnt_zero_i,
  output logic cnt_load_o,
  output logic cnt_dec_o,
  output logic ev_bcl_o,
  output logic ev_done_o,
  output logic sda_pd_o,
  output logic scl_pd_o
);
  sg_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_dec_o  = 1'b0;
    ev_bcl_o   = 1'b0;
    ev_done_o  = 1'b0;
    unique case (state_q)
      SG_IDLE: begin
        if (start_i) begin
          if (!sda_s_i || !scl_s_i) begin
            ev_bcl_o = 1'b1;
          end else begin
            state_d    = SG_PH1;
            cnt_load_o = 1'b1;
          end
        end
      end
      SG_PH1: begin
        if (!scl_s_i && sda_s_i) begin
          // another master drives a one
          ev_bcl_o = 1'b1;
          state_d  = SG_IDLE;
        end else if (!sda_s_i || cnt_zero_i) begin
          // early assert or normal end of first delay
          state_d    = SG_PH2;
          cnt_load_o = 1'b1;
        end else begin
          cnt_dec_o = 1'b1;
        end
      end
      SG_PH2: begin
        if (cnt_zero_i) begin
          state_d   = SG_DONE;
          ev_done_o = 1'b1;
        end else begin
          cnt_dec_o = 1'b1;
        end
      end
      SG_DONE: state_d = SG_DONE;
      default: state_d = SG_IDLE;
    endcase
    if (srst_i) begin
      state_d    = SG_IDLE;
      cnt_load_o = 1'b0;
      cnt_dec_o  = 1'b0;
      ev_bcl_o   = 1'b0;
      ev_done_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SG_IDLE;
    else         state_q <= state_d;
  end

  assign sda_pd_o = (state_q == SG_PH2) || (state_q == SG_DONE);
  assign scl_pd_o = (state_q == SG_DONE);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_sg_pkg::*;
#(
  parameter int unsigned RELOAD_W = i2c_sg_pkg::RELOAD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                srst_i,
  input  logic                start_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                sda_i,
  input  logic                scl_i,
  input  logic                irq_clr_i,
  input  logic                bcl_clr_i,
  output logic                sda_pd_o,
  output logic                scl_pd_o,
  output logic                irq_o,
  output logic                bcl_o,
  output logic                start_clr_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] lines_s;
  logic cnt_load, cnt_dec, cnt_zero, ev_bcl, ev_done;
  logic irq_q, bcl_q, clr_q;

  i2c_sg_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  i2c_sg_cnt #(.WIDTH(RELOAD_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst_i),
    .load_i  (cnt_load),
    .dec_i   (cnt_dec),
    .reload_i(reload_i),
    .zero_o  (cnt_zero)
  );

  i2c_sg_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst_i),
    .start_i   (start_i),
    .sda_s_i   (lines_s[0]),
    .scl_s_i   (lines_s[1]),
    .cnt_zero_i(cnt_zero),
    .cnt_load_o(cnt_load),
    .cnt_dec_o (cnt_dec),
    .ev_bcl_o  (ev_bcl),
    .ev_done_o (ev_done),
    .sda_pd_o  (sda_pd_o),
    .scl_pd_o  (scl_pd_o)
  );

  // set wins over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      bcl_q <= 1'b0;
      clr_q <= 1'b0;
    end else if (srst_i) begin
      irq_q <= 1'b0;
      bcl_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= ev_bcl | ev_done;
      if (ev_bcl || ev_done) irq_q <= 1'b1;
      else if (irq_clr_i)    irq_q <= 1'b0;
      if (ev_bcl)            bcl_q <= 1'b1;
      else if (bcl_clr_i)    bcl_q <= 1'b0;
    end
  end

  assign irq_o       = irq_q;
  assign bcl_o       = bcl_q;
  assign start_clr_o = clr_q;
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk #(
  parameter int unsigned RELOAD_W = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                srst_i,
  input logic                start_i,
  input logic [RELOAD_W-1:0] reload_i,
  input logic                sda_i,
  input logic                scl_i,
  input logic                irq_clr_i,
  input logic                bcl_clr_i,
  input logic                sda_pd_o,
  input logic                scl_pd_o,
  input logic                irq_o,
  input logic                bcl_o,
  input logic                start_clr_o
);
  a_r6_scl_after_sda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pd_o |-> sda_pd_o);

  a_r6_done_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_pd_o) |-> (irq_o && start_clr_o && !bcl_o));

  a_r6_clr_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_clr_o |=> !start_clr_o);

  a_r4_bcl_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bcl_o) |-> (irq_o && start_clr_o && !sda_pd_o && !scl_pd_o));

  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i && !srst_i) |=> irq_o);

  a_r8_bcl_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcl_o && !bcl_clr_i && !srst_i) |=> bcl_o);

  a_r10_srst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!sda_pd_o && !scl_pd_o && !irq_o && !bcl_o));
endmodule

bind i2c_start_gen i2c_start_gen_chk #(.RELOAD_W(RELOAD_W)) u_chk (.*);

// File: tb/i2c_start_gen_tb_top.sv
module i2c_start_gen_tb_top;
  localparam int unsigned RW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srst = 1'b0, start = 1'b0, irq_clr = 1'b0, bcl_clr = 1'b0;
  logic [RW-1:0] reload = '0;
  logic ext_sda_lo = 1'b0, ext_scl_lo = 1'b0;
  logic sda_pd, scl_pd, irq, bcl, sclr;
  logic sda_line, scl_line;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = ~(sda_pd | ext_sda_lo);
  assign scl_line = ~(scl_pd | ext_scl_lo);

  i2c_start_gen #(.RELOAD_W(RW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .start_i(start),
    .reload_i(reload), .sda_i(sda_line), .scl_i(scl_line),
    .irq_clr_i(irq_clr), .bcl_clr_i(bcl_clr),
    .sda_pd_o(sda_pd), .scl_pd_o(scl_pd), .irq_o(irq), .bcl_o(bcl),
    .start_clr_o(sclr)
  );

  function automatic int sda_edge(int r); return r + 1; endfunction
  function automatic int scl_edge(int r); return 2 * r + 2; endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic pulse_start(); start = 1'b1; tick(); start = 1'b0; endtask

  task automatic soft_reset();
    srst = 1'b1; tick(); srst = 1'b0;
    chk("R10 sda released", sda_pd, 0);
    chk("R10 scl released", scl_pd, 0);
    chk("R10 flags", {irq, bcl}, 0);
    tick(); tick(); tick();
  endtask

  // pulse leaves us at the negedge after the accepting edge E0
  task automatic run_nominal(int r);
    reload = r[RW-1:0];
    pulse_start();
    repeat (sda_edge(r) - 1) tick();
    chk("R3 sda before phase end", sda_pd, 0);
    tick();
    chk("R3 sda at phase end", sda_pd, 1);
    chk("R6 scl still free", scl_pd, 0);
    repeat (scl_edge(r) - sda_edge(r) - 1) tick();
    chk("R6 scl before phase end", scl_pd, 0);
    tick();
    chk("R6 scl driven", scl_pd, 1);
    chk("R6 irq", irq, 1);
    chk("R6 no bcl", bcl, 0);
    chk("R6 start clear", sclr, 1);
    tick();
    chk("R6 start clear one cycle", sclr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 sda", sda_pd, 0); chk("R1 scl", scl_pd, 0);
    chk("R1 irq", irq, 0); chk("R1 bcl", bcl, 0); chk("R1 clr", sclr, 0);
    rst_n = 1'b1;
    tick(); tick(); tick();

    run_nominal(0);
    soft_reset();
    run_nominal(9);

    // R8: clears are independent and sticky otherwise
    tick(); tick();
    chk("R8 irq held", irq, 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    chk("R8 irq cleared", irq, 0);
    // R9 request in done state changes nothing
    pulse_start();
    tick();
    chk("R9 done ignores start scl", scl_pd, 1);
    chk("R9 done ignores start sda", sda_pd, 1);
    chk("R9 done ignores start irq", irq, 0);
    chk("R9 done ignores start clr", sclr, 0);
    soft_reset();

    // R2 SDA already low at request
    ext_sda_lo = 1'b1; tick(); tick(); tick();
    pulse_start();
    chk("R2 bcl", bcl, 1); chk("R2 irq", irq, 1); chk("R2 clr", sclr, 1);
    chk("R2 no sda", sda_pd, 0); chk("R2 no scl", scl_pd, 0);
    ext_sda_lo = 1'b0;
    bcl_clr = 1'b1; tick(); bcl_clr = 1'b0;
    chk("R8 bcl cleared", bcl, 0);
    chk("R8 irq kept", irq, 1);
    soft_reset();

    // R2 SCL already low at request
    ext_scl_lo = 1'b1; tick(); tick(); tick();
    pulse_start();
    chk("R2 scl-low bcl", bcl, 1); chk("R2 scl-low no sda", sda_pd, 0);
    ext_scl_lo = 1'b0;
    soft_reset();

    // R4 + R11: SCL low during first phase
    reload = 7'd10;
    pulse_start();
    ext_scl_lo = 1'b1;
    tick(); tick();
    chk("R11 not yet seen", bcl, 0);
    tick();
    chk("R4 bcl", bcl, 1); chk("R4 irq", irq, 1); chk("R4 clr", sclr, 1);
    chk("R4 sda released", sda_pd, 0);
    ext_scl_lo = 1'b0;
    tick(); tick(); tick(); tick();
    chk("R4 stays idle", sda_pd, 0);
    soft_reset();

    // R5: SDA low during first phase
    reload = 7'd20;
    pulse_start();
    ext_sda_lo = 1'b1;
    tick(); tick();
    chk("R5 not yet driven", sda_pd, 0);
    tick();
    chk("R5 early drive", sda_pd, 1);
    chk("R5 no bcl", bcl, 0);
    repeat (20) tick();
    chk("R5 second phase full length", scl_pd, 0);
    tick();
    chk("R5 scl at end", scl_pd, 1);
    chk("R5 no bcl at end", bcl, 0);
    ext_sda_lo = 1'b0;
    soft_reset();

    // R7: SCL low during second phase ignored
    reload = 7'd5;
    pulse_start();
    repeat (6) tick();
    chk("R7 in phase two", sda_pd, 1);
    ext_scl_lo = 1'b1;
    repeat (5) tick();
    chk("R7 no bcl", bcl, 0);
    chk("R7 scl not yet", scl_pd, 0);
    tick();
    chk("R7 scl driven", scl_pd, 1);
    chk("R7 irq", irq, 1);
    chk("R7 bcl stays 0", bcl, 0);
    ext_scl_lo = 1'b0;
    soft_reset();

    // R9: request while busy
    reload = 7'd8;
    pulse_start();
    tick(); tick(); tick();
    pulse_start();
    repeat (4) tick();
    chk("R9 busy timing sda", sda_pd, 0);
    tick();
    chk("R9 busy timing sda", sda_pd, 1);
    repeat (9) tick();
    chk("R9 busy timing scl", scl_pd, 1);
    soft_reset();

    // R3/R6 random reloads
    for (int i = 0; i < 16; i++) begin
      run_nominal(int'($urandom_range(0, 30)));
      soft_reset();
    end
    run_nominal(127);
    soft_reset();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule